// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Controller

This block sits behind a 32-bit register port and turns a demodulated infrared input into a stream of measured symbols. The input passes through a two-flop synchronizer. Every symbol is a low (pulse) phase followed by a high (space) phase. Each phase is counted in time units produced by a prescaler. A programmed frequency field divides the clock down to 1 MHz, and that rate is divided by a further fixed factor (10 by default). Each finished symbol is packed into one word and pushed into a receive FIFO. Software reads the FIFO through a count register and a pop-on-read data register.

When the line stays high long enough for a symbol's total to reach the programmed maximum width, the symbol is closed and stored, and a timeout is flagged. Three sticky events can raise the interrupt line, each subject to its mask: symbols received, timeout and overflow. On overflow the FIFO keeps what it already holds, and software drains it. A duration that would pass 0xFFFF saturates at 0xFFFF.

Software uses the block in this order:
- write the enable register;
- wait for busy to read zero;
- program the configuration;
- write the start register.

Top module: `irrx_top`

## Requirements
- R1: After reset the registers read as follows: enable (word 0x00) reads 0, busy (0x1C) reads 0, count (0x20) reads 0, status (0x2C) reads 0, mask (0x28) reads 0x0000_0700, configuration (0x04) reads 0x3E80_0080. The irq output is 0.
- R2: Writing 1 to enable bit 0 while the block is disabled makes busy read 1 for a short settling window. Busy then reads 0.
- R3: A write to the start register (0x34) is ignored while the block is disabled or busy. No symbols are captured until a start is accepted.
- R4: The configuration word has these fields: bits 31:16 are the maximum width, bits 13:8 are the level, bit 7 is raw mode and bits 6:0 are the frequency in MHz minus one. A symbol is packed with its pulse duration in bits 15:0 and its space duration in bits 31:16. Each duration is the number of whole time units (10 µs) the phase lasted. A symbol is closed by the falling edge that starts the next pulse.
- R5: When the space phase makes pulse plus space reach the maximum width, the symbol is stored with space = maximum - pulse. The timeout event (status bit 9, raw bit 25) is then set.
- R6: Count (0x20) reads the number of stored symbols. Each read of data (0x24) returns the oldest symbol and removes it. A read of data while the FIFO is empty returns 0.
- R7: The received event (bit 8, raw bit 24) is set when a push leaves the FIFO holding more symbols than the level field.
- R8: A push into a full FIFO (64 entries) is dropped and sets the overflow event (bit 10, raw bit 26). The stored symbols are kept.
- R9: Mask bits 10:8 gate events 10:8, where a 0 lets the event through. Status bits 26:24 show the raw events and bits 10:8 the unmasked ones. irq is high when any unmasked event is set.
- R10: Writing 1 to bit 16, 17 or 18 of the clear register (0x30) clears the received, timeout or overflow event respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the phase measurement at whole-unit boundaries. A design that counted an edge cycle as an extra unit, or swapped the two halfwords, would return wrong symbol words. It also drives a space that runs to the maximum width. A wrong comparison would store a space that is one unit off, or no symbol at all. The bench overfills the FIFO and checks that the oldest entries survive and the count stops at 64. It also checks that a level above zero holds back the received event until the FIFO has one symbol more than the level. A start written while the block is disabled must capture nothing.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

  // Word index of each register (byte address bits 7:2).
  localparam logic [5:0] ADR_ENABLE = 6'h00;
  localparam logic [5:0] ADR_CONFIG = 6'h01;
  localparam logic [5:0] ADR_BUSY   = 6'h07;
  localparam logic [5:0] ADR_COUNT  = 6'h08;
  localparam logic [5:0] ADR_DATA   = 6'h09;
  localparam logic [5:0] ADR_MASK   = 6'h0A;
  localparam logic [5:0] ADR_STATUS = 6'h0B;
  localparam logic [5:0] ADR_CLEAR  = 6'h0C;
  localparam logic [5:0] ADR_START  = 6'h0D;

  localparam logic [31:0] CONFIG_RESET = 32'h3E80_0080;

  // Event bit order inside the 3-bit sticky vector.
  localparam int EV_RCV = 0;
  localparam int EV_TMO = 1;
  localparam int EV_OVF = 2;

  typedef enum logic [1:0] {
    MS_OFF,
    MS_WAIT,
    MS_PULSE,
    MS_SPACE
  } meter_state_t;

endpackage

// File: rtl/irrx_tick.sv
module irrx_tick #(
  parameter int FREQ_W  = 7,
  parameter int UNIT_US = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              run,
  input  logic              clr,
  input  logic [FREQ_W-1:0] freq_m1,
  output logic              unit_tick
);
  localparam int UW = (UNIT_US > 1) ? $clog2(UNIT_US) : 1;

  logic [FREQ_W-1:0] us_q, us_n;
  logic [UW-1:0]     un_q, un_n;
  logic              us_tick;

  assign us_tick   = run && (us_q == freq_m1);
  assign unit_tick = us_tick && (un_q == UW'(UNIT_US - 1));

  always_comb begin
    us_n = us_q;
    un_n = un_q;
    if (clr || !run) begin
      us_n = '0;
      un_n = '0;
    end else if (us_tick) begin
      us_n = '0;
      un_n = unit_tick ? '0 : un_q + 1'b1;
    end else begin
      us_n = us_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      us_q <= '0;
      un_q <= '0;
    end else begin
      us_q <= us_n;
      un_q <= un_n;
    end
  end
endmodule

// File: rtl/irrx_meter.sv
module irrx_meter
  import irrx_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             ir_in,
  input  logic             unit_tick,
  input  logic [DUR_W-1:0] max_w,
  output logic             presc_run,
  output logic             presc_clr,
  output logic             push,
  output logic [2*DUR_W-1:0] push_word,
  output logic             tmo_evt
);
  logic s1_q, s2_q, prev_q;
  logic fall, rise;
  meter_state_t st_q, st_n;
  logic [DUR_W-1:0] pul_q, pul_n, spc_q, spc_n, spc_inc, pul_inc;
  logic push_c, tmo_c;

  // Two-flop synchronizer plus an edge-detect stage, idle high.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= ir_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall = prev_q && !s2_q;
  assign rise = !prev_q && s2_q;

  // Saturating increments.
  assign pul_inc = (&pul_q) ? pul_q : pul_q + 1'b1;
  assign spc_inc = (&spc_q) ? spc_q : spc_q + 1'b1;

  always_comb begin
    st_n      = st_q;
    pul_n     = pul_q;
    spc_n     = spc_q;
    push_c    = 1'b0;
    tmo_c     = 1'b0;
    presc_clr = 1'b0;
    push_word = {spc_q, pul_q};
    unique case (st_q)
      MS_OFF: if (run) st_n = MS_WAIT;
      MS_WAIT: if (fall) begin
        st_n = MS_PULSE; pul_n = '0; presc_clr = 1'b1;
      end
      MS_PULSE: if (rise) begin
        st_n = MS_SPACE; spc_n = '0; presc_clr = 1'b1;
      end else if (unit_tick) begin
        pul_n = pul_inc;
      end
      MS_SPACE: if (fall) begin
        push_c = 1'b1; st_n = MS_PULSE; pul_n = '0; presc_clr = 1'b1;
      end else if (unit_tick) begin
        spc_n = spc_inc;
        if ({1'b0, pul_q} + {1'b0, spc_inc} >= {1'b0, max_w}) begin
          push_c    = 1'b1;
          tmo_c     = 1'b1;
          push_word = {spc_inc, pul_q};
          st_n      = MS_WAIT;
        end
      end
      default: st_n = MS_OFF;
    endcase
    if (!run) st_n = MS_OFF;
  end

  assign push      = push_c && run;
  assign tmo_evt   = tmo_c && run;
  assign presc_run = (st_q == MS_PULSE) || (st_q == MS_SPACE);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MS_OFF;
      pul_q <= '0;
      spc_q <= '0;
    end else begin
      st_q  <= st_n;
      pul_q <= pul_n;
      spc_q <= spc_n;
    end
  end
endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_ok = push && !full && !flush;
  assign rd_ok = pop && (cnt_q != '0) && !flush;
  assign dout  = (cnt_q != '0) ? mem[rp_q] : '0;
  assign cnt   = cnt_q;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (wr_ok) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rd_ok) rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (wr_ok && !rd_ok) cnt_n = cnt_q + 1'b1;
      else if (!wr_ok && rd_ok) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= din;
  end
endmodule

// File: rtl/irrx_top.sv
module irrx_top
  import irrx_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int UNIT_US  = 10,
  parameter int BUSY_CYC = 4,
  parameter int DUR_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int BW     = $clog2(BUSY_CYC + 1);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int WORD_W = 2 * DUR_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [5:0]    word;
  logic          en_q, en_n, run_q, run_n;
  logic [BW-1:0] busy_q, busy_n;
  logic          busy_w;
  logic [31:0]   cfg_q, cfg_n;
  logic [2:0]    mask_q, mask_n, stk_q, stk_n, ev_set;
  logic          clr_hit, pop_req;
  logic          unit_tick, presc_run, presc_clr;
  logic          meter_push, tmo_evt;
  logic [WORD_W-1:0] push_word, fifo_dout;
  logic [CW-1:0] fifo_cnt;
  logic          fifo_full;

  assign word    = reg_addr[7:2];
  assign busy_w  = (busy_q != '0);
  assign clr_hit = reg_wr && (word == ADR_CLEAR);
  assign pop_req = reg_rd && (word == ADR_DATA);

  irrx_tick #(.FREQ_W(7), .UNIT_US(UNIT_US)) u_tick (
    .clk(clk), .rst_ni(rst_ni), .run(presc_run), .clr(presc_clr),
    .freq_m1(cfg_q[6:0]), .unit_tick(unit_tick)
  );

  irrx_meter #(.DUR_W(DUR_W)) u_meter (
    .clk(clk), .rst_ni(rst_ni), .run(run_q), .ir_in(ir_in),
    .unit_tick(unit_tick), .max_w(cfg_q[31:16]),
    .presc_run(presc_run), .presc_clr(presc_clr),
    .push(meter_push), .push_word(push_word), .tmo_evt(tmo_evt)
  );

  irrx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_ni(rst_ni), .flush(!en_q),
    .push(meter_push), .din(push_word), .pop(pop_req),
    .dout(fifo_dout), .cnt(fifo_cnt), .full(fifo_full)
  );

  // Event sources.
  always_comb begin
    ev_set         = '0;
    ev_set[EV_RCV] = meter_push && !fifo_full &&
                     ({1'b0, fifo_cnt} + 1'b1 > (CW + 1)'(cfg_q[13:8]));
    ev_set[EV_TMO] = tmo_evt;
    ev_set[EV_OVF] = meter_push && fifo_full;
  end

  always_comb begin
    en_n   = en_q;
    cfg_n  = cfg_q;
    mask_n = mask_q;
    busy_n = busy_w ? busy_q - 1'b1 : busy_q;
    run_n  = run_q;
    stk_n  = stk_q;
    if (reg_wr) begin
      unique case (word)
        ADR_ENABLE: begin
          en_n = reg_wdata[0];
          if (reg_wdata[0] && !en_q) busy_n = BW'(BUSY_CYC);
        end
        ADR_CONFIG: cfg_n  = reg_wdata;
        ADR_MASK:   mask_n = reg_wdata[10:8];
        ADR_START:  if (en_q && !busy_w) run_n = 1'b1;
        default: ;
      endcase
    end
    if (!en_n) run_n = 1'b0;
    if (clr_hit) stk_n = stk_q & ~reg_wdata[18:16];
    stk_n = stk_n | ev_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      busy_q <= '0;
      cfg_q  <= CONFIG_RESET;
      mask_q <= 3'b111;
      stk_q  <= '0;
    end else begin
      en_q   <= en_n;
      run_q  <= run_n;
      busy_q <= busy_n;
      cfg_q  <= cfg_n;
      mask_q <= mask_n;
      stk_q  <= stk_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (word)
        ADR_ENABLE: reg_rdata = {31'b0, en_q};
        ADR_CONFIG: reg_rdata = cfg_q;
        ADR_BUSY:   reg_rdata = {31'b0, busy_w};
        ADR_COUNT:  reg_rdata = 32'(fifo_cnt);
        ADR_DATA:   reg_rdata = 32'(fifo_dout);
        ADR_MASK:   reg_rdata = {21'b0, mask_q, 8'b0};
        ADR_STATUS: reg_rdata = {5'b0, stk_q, 13'b0, stk_q & ~mask_q, 8'b0};
        default:    reg_rdata = '0;
      endcase
    end
  end

  assign irq = |(stk_q & ~mask_q);
endmodule

// File: rtl/irrx_chk.sv
module irrx_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          en_q,
  input logic          run_q,
  input logic          busy_w,
  input logic          meter_push,
  input logic          fifo_full,
  input logic          pop_req,
  input logic [CW-1:0] fifo_cnt,
  input logic          tmo_evt,
  input logic [2:0]    stk_q,
  input logic          clr_hit,
  input logic [31:0]   reg_wdata
);
  assert_run_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    run_q |-> en_q);

  assert_start_after_settle_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(run_q) |-> $past(en_q && !busy_w));

  assert_full_keeps_contents_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (meter_push && fifo_full && !pop_req && en_q) |=> (fifo_cnt == CW'(DEPTH)) && stk_q[2]);

  assert_timeout_flags_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    tmo_evt |=> stk_q[1]);

  assert_clear_timeout_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_hit && reg_wdata[17] && !tmo_evt) |=> !stk_q[1]);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));
endmodule

bind irrx_top irrx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .en_q(en_q), .run_q(run_q), .busy_w(busy_w),
  .meter_push(meter_push), .fifo_full(fifo_full), .pop_req(pop_req),
  .fifo_cnt(fifo_cnt), .tmo_evt(tmo_evt), .stk_q(stk_q),
  .clr_hit(clr_hit), .reg_wdata(reg_wdata)
);

// File: tb/sim_irrx_top.sv
module sim_irrx_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ir_in;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_EN = 8'h00, A_CFG = 8'h04, A_BUSY = 8'h1C,
    A_CNT = 8'h20, A_DAT = 8'h24, A_MSK = 8'h28, A_STS = 8'h2C,
    A_CLR = 8'h30, A_GO = 8'h34;

  always #2.5 clk = ~clk;

  irrx_top u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FIX %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // Hold the line at v for the given number of 10-cycle units plus half a unit.
  task automatic line(input logic v, input int units);
    ir_in = v;
    repeat (units * 10 + 5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_EN, d);   chk("R1 enable", d, 32'h0);
    rd(A_BUSY, d); chk("R1 busy", d, 32'h0);
    rd(A_CNT, d);  chk("R1 count", d, 32'h0);
    rd(A_STS, d);  chk("R1 status", d, 32'h0);
    rd(A_MSK, d);  chk("R1 mask", d, 32'h0000_0700);
    rd(A_CFG, d);  chk("R1 config", d, 32'h3E80_0080);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_start_gate;
    logic [31:0] d;
    wr(A_GO, 32'h1);
    line(1'b0, 2); line(1'b1, 2); line(1'b0, 1); line(1'b1, 2);
    rd(A_CNT, d); chk("R3 no capture while disabled", d, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(A_EN, 32'h1);
    rd(A_BUSY, d); chk("R2 busy after enable", d, 32'h1);
    repeat (8) @(negedge clk);
    rd(A_BUSY, d); chk("R2 busy settles", d, 32'h0);
  endtask

  task automatic t_symbols;
    logic [31:0] d;
    wr(A_CFG, 32'h0014_0080);
    wr(A_MSK, 32'h0);
    wr(A_GO, 32'h1);
    line(1'b0, 3); line(1'b1, 4); line(1'b0, 7); line(1'b1, 2);
    line(1'b0, 1); line(1'b1, 25);
    rd(A_CNT, d); chk("R6 count three", d, 32'd3);
    rd(A_STS, d); chk("R5 R7 status rcv+tmo", d, 32'h0300_0300);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    rd(A_DAT, d); chk("R4 first symbol", d, 32'h0004_0003);
    rd(A_DAT, d); chk("R4 second symbol", d, 32'h0002_0007);
    rd(A_DAT, d); chk("R5 timeout symbol", d, 32'h0013_0001);
    rd(A_DAT, d); chk("R6 empty pop", d, 32'h0);
    rd(A_CNT, d); chk("R6 count drained", d, 32'h0);
  endtask

  task automatic t_mask_clear;
    logic [31:0] d;
    wr(A_MSK, 32'h0000_0700);
    rd(A_STS, d); chk("R9 masked status", d, 32'h0300_0000);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(A_MSK, 32'h0);
    wr(A_CLR, 32'h0002_0000);
    rd(A_STS, d); chk("R10 clear timeout only", d, 32'h0100_0100);
    wr(A_CLR, 32'h0001_0000);
    rd(A_STS, d); chk("R10 clear received", d, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(A_CFG, 32'h0014_0280);
    line(1'b0, 1); line(1'b1, 1); line(1'b0, 1); line(1'b1, 1); line(1'b0, 1);
    rd(A_CNT, d); chk("R7 two held", d, 32'd2);
    rd(A_STS, d); chk("R7 no rcv at level", d, 32'h0);
    line(1'b1, 1); line(1'b0, 1);
    rd(A_STS, d); chk("R7 rcv above level", d, 32'h0100_0100);
    line(1'b1, 25);
    rd(A_CNT, d); chk("R6 four held", d, 32'd4);
    rd(A_DAT, d); chk("R4 level symbol", d, 32'h0001_0001);
    for (int i = 0; i < 3; i++) rd(A_DAT, d);
    chk("R5 last timeout symbol", d, 32'h0013_0001);
    wr(A_CLR, 32'h0007_0000);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    wr(A_CFG, 32'h0014_0080);
    for (int i = 0; i < 66; i++) begin
      line(1'b0, 1); line(1'b1, 1);
    end
    line(1'b0, 1); line(1'b1, 25);
    rd(A_CNT, d); chk("R8 count capped", d, 32'd64);
    rd(A_STS, d); chk("R8 overflow flagged", d, 32'h0700_0700);
    rd(A_DAT, d); chk("R8 oldest kept", d, 32'h0001_0001);
    for (int i = 0; i < 63; i++) rd(A_DAT, d);
    chk("R8 last kept", d, 32'h0001_0001);
    rd(A_CNT, d); chk("R6 drained after overflow", d, 32'h0);
    wr(A_CLR, 32'h0004_0000);
    rd(A_STS, d); chk("R10 clear overflow", d, 32'h0300_0300);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ir_in = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start_gate();
    t_enable();
    t_symbols();
    t_mask_clear();
    t_level();
    t_overflow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule